// File: doc/BRIEF.md
# Deferred-Write Store Buffer with Load Forwarding

This block sits beside the memory stage of an in-order pipeline and takes the data-array write of a store out of the cycle in which the store's tag lookup happens. A store whose lookup hits is parked as an entry holding its address, its value and the cache way it hit in. The entry reaches the data array later, when another store comes into the lookup stage, when a load miss needs the buffer empty, or when a drain is requested. Entries leave in the order they arrived, at most one per cycle, and only in cycles when the data-array write port is free.

Loads in the lookup stage compare their address with every parked entry. A hitting load that matches takes its data from the youngest matching entry instead of from the array. A load that misses is held until the buffer is empty, so that no deferred write can reach a line that the refill is about to replace. All accesses are full words, so an address either matches exactly or not at all.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the buffer is empty: `empty_o`=1, `full_o`=0, `wr_en_o`=0 and `st_ready_o`=1.
- R2: A store presented with `st_hit_i`=1 and accepted (`st_ready_o`=1) becomes a parked entry and causes no array write by itself. A store with `st_hit_i`=0 is never parked.
- R3: In any cycle with `st_valid_i`=1, a non-empty buffer and `arr_busy_i`=0, the oldest entry is written in that same cycle: `wr_en_o`=1 with that entry's address, value and way on `wr_addr_o`, `wr_data_o`, `wr_way_o`.
- R4: Entries are written to the array in the order in which their stores were accepted, and the array ends up holding the value of the last accepted store to each address.
- R5: A load with `ld_hit_i`=1 whose address matches one or more parked entries gets `ld_fwd_o`=1 in the same cycle, and `ld_fwd_data_o` carries the value of the youngest matching entry.
- R6: A load with `ld_hit_i`=0 sees `ld_stall_o`=1 while the buffer is non-empty; during that stall one entry is written per free-port cycle, and the stall drops in the first cycle the buffer is empty.
- R7: While `drain_i`=1, one entry is written per cycle in which the port is free; `drained_o`=1 exactly when `drain_i`=1 and the buffer is empty.
- R8: With DEPTH entries parked, `full_o`=1; if no entry leaves in that cycle (`arr_busy_i`=1), `st_ready_o`=0 and the store is not parked.
- R9: No array write occurs in a cycle with `arr_busy_i`=1.
- R10: A hitting load that matches no parked entry gets `ld_fwd_o`=0 and is served from the array.
- R11: `full_o` and `empty_o` are never both 1, and each follows the number of parked entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | A store is in the lookup stage |
| st_hit_i | input | 1 | Lookup result of that store |
| st_addr_i | input | ADDR_W | Store word address |
| st_data_i | input | DATA_W | Store value |
| st_way_i | input | WAY_W | Way the store hit in |
| st_ready_o | output | 1 | Store can be taken this cycle |
| ld_valid_i | input | 1 | A load is in the lookup stage |
| ld_hit_i | input | 1 | Lookup result of that load |
| ld_addr_i | input | ADDR_W | Load word address |
| ld_fwd_o | output | 1 | Load value comes from the buffer |
| ld_fwd_data_o | output | DATA_W | Forwarded value |
| ld_stall_o | output | 1 | Load held until the buffer empties |
| drain_i | input | 1 | Request to empty the buffer |
| drained_o | output | 1 | Drain requested and buffer empty |
| arr_busy_i | input | 1 | Data-array write port taken this cycle |
| wr_en_o | output | 1 | Data-array write strobe |
| wr_addr_o | output | ADDR_W | Data-array write address |
| wr_data_o | output | DATA_W | Data-array write value |
| wr_way_o | output | WAY_W | Data-array write way |
| full_o | output | 1 | DEPTH entries parked |
| empty_o | output | 1 | No entries parked |

## Verification
The bench builds the block with DEPTH=4, 8-bit addresses, 16-bit values and 2-bit ways. Four entries are few enough that holding the write port busy fills the buffer in four stores, so the full stall, the wrap of the circular pointers and a four-deep load-miss drain all occur within a short directed sequence. The narrow address space lets the random phase confine traffic to eight words, so repeated stores to one address sit in the buffer together and the youngest-match selection is exercised often.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    RC_NONE,
    RC_STORE,
    RC_LOAD_MISS,
    RC_DRAIN
  } retire_cause_e;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAY_W  = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [WAY_W-1:0]  push_way_i,
  output logic [PW-1:0]     head_o,
  output logic [CW-1:0]     count_o,
  output logic [ADDR_W-1:0] addr_q_o [DEPTH],
  output logic [DATA_W-1:0] data_q_o [DEPTH],
  output logic [WAY_W-1:0]  way_q_o  [DEPTH],
  output logic              full_o,
  output logic              empty_o
);
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) tail_q <= ptr_next(tail_q);
      if (pop_i)  head_q <= ptr_next(head_q);
      count_q <= count_q + CW'(push_i) - CW'(pop_i);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && tail_q == PW'(g)) begin
        addr_q_o[g] <= push_addr_i;
        data_q_o[g] <= push_data_i;
        way_q_o[g]  <= push_way_i;
      end
    end
  end

  assign head_o  = head_q;
  assign count_o = count_q;
  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [PW-1:0]     head_i,
  input  logic [CW-1:0]     count_i,
  input  logic [ADDR_W-1:0] addr_q_i [DEPTH],
  input  logic [DATA_W-1:0] data_q_i [DEPTH],
  output logic              match_o,
  output logic [DATA_W-1:0] data_o
);
  // walk oldest to youngest so the last match wins
  always_comb begin
    match_o = 1'b0;
    data_o  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int idx;
      idx = int'(head_i) + k;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if (k < int'(count_i) && addr_q_i[PW'(idx)] == ld_addr_i) begin
        match_o = 1'b1;
        data_o  = data_q_i[PW'(idx)];
      end
    end
  end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
(
  input  logic st_valid_i,
  input  logic st_hit_i,
  input  logic ld_valid_i,
  input  logic ld_hit_i,
  input  logic drain_i,
  input  logic arr_busy_i,
  input  logic empty_i,
  input  logic full_i,
  output logic push_o,
  output logic pop_o,
  output logic st_ready_o,
  output logic ld_stall_o,
  output logic drained_o
);
  retire_cause_e cause;

  always_comb begin
    if (empty_i || arr_busy_i)          cause = RC_NONE;
    else if (st_valid_i)                cause = RC_STORE;
    else if (ld_valid_i && !ld_hit_i)   cause = RC_LOAD_MISS;
    else if (drain_i)                   cause = RC_DRAIN;
    else                                cause = RC_NONE;
  end

  assign pop_o      = (cause != RC_NONE);
  assign st_ready_o = !full_i || pop_o;
  assign push_o     = st_valid_i && st_hit_i && st_ready_o;
  assign ld_stall_o = ld_valid_i && !ld_hit_i && !empty_i;
  assign drained_o  = drain_i && empty_i;
endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAY_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  input  logic              st_hit_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [WAY_W-1:0]  st_way_i,
  output logic              st_ready_o,
  input  logic              ld_valid_i,
  input  logic              ld_hit_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic              ld_fwd_o,
  output logic [DATA_W-1:0] ld_fwd_data_o,
  output logic              ld_stall_o,
  input  logic              drain_i,
  output logic              drained_o,
  input  logic              arr_busy_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [WAY_W-1:0]  wr_way_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic              push, pop, q_full, q_empty, match;
  logic [PW-1:0]     head;
  logic [CW-1:0]     count;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [WAY_W-1:0]  way_q  [DEPTH];
  logic [DATA_W-1:0] fwd_data;

  sb_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAY_W(WAY_W)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .pop_i      (pop),
    .push_addr_i(st_addr_i),
    .push_data_i(st_data_i),
    .push_way_i (st_way_i),
    .head_o     (head),
    .count_o    (count),
    .addr_q_o   (addr_q),
    .data_q_o   (data_q),
    .way_q_o    (way_q),
    .full_o     (q_full),
    .empty_o    (q_empty)
  );

  sb_fwd #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
    .ld_addr_i(ld_addr_i),
    .head_i   (head),
    .count_i  (count),
    .addr_q_i (addr_q),
    .data_q_i (data_q),
    .match_o  (match),
    .data_o   (fwd_data)
  );

  sb_ctrl u_ctrl (
    .st_valid_i(st_valid_i),
    .st_hit_i  (st_hit_i),
    .ld_valid_i(ld_valid_i),
    .ld_hit_i  (ld_hit_i),
    .drain_i   (drain_i),
    .arr_busy_i(arr_busy_i),
    .empty_i   (q_empty),
    .full_i    (q_full),
    .push_o    (push),
    .pop_o     (pop),
    .st_ready_o(st_ready_o),
    .ld_stall_o(ld_stall_o),
    .drained_o (drained_o)
  );

  assign wr_en_o       = pop;
  assign wr_addr_o     = addr_q[head];
  assign wr_data_o     = data_q[head];
  assign wr_way_o      = way_q[head];
  assign ld_fwd_o      = ld_valid_i && ld_hit_i && match;
  assign ld_fwd_data_o = fwd_data;
  assign full_o        = q_full;
  assign empty_o       = q_empty;
endmodule

// File: rtl/sb_checker.sv
module sb_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic st_valid_i,
  input logic st_ready_o,
  input logic ld_valid_i,
  input logic ld_hit_i,
  input logic ld_fwd_o,
  input logic ld_stall_o,
  input logic drain_i,
  input logic drained_o,
  input logic arr_busy_i,
  input logic wr_en_o,
  input logic full_o,
  input logic empty_o
);
  assert_flags_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  assert_busy_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_busy_i |-> !wr_en_o);

  assert_store_retires_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && !empty_o && !arr_busy_i) |-> wr_en_o);

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && arr_busy_i) |-> !st_ready_o);

  assert_miss_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && !ld_hit_i && !empty_o) |-> ld_stall_o);

  assert_drain_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_i && !empty_o && !arr_busy_i) |-> wr_en_o);

  assert_drained_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drained_o |-> empty_o);

  assert_write_has_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !empty_o);

  assert_fwd_on_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_fwd_o |-> (ld_valid_i && ld_hit_i && !empty_o));
endmodule

bind store_fwd_buffer sb_checker u_sb_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .st_valid_i(st_valid_i),
  .st_ready_o(st_ready_o),
  .ld_valid_i(ld_valid_i),
  .ld_hit_i  (ld_hit_i),
  .ld_fwd_o  (ld_fwd_o),
  .ld_stall_o(ld_stall_o),
  .drain_i   (drain_i),
  .drained_o (drained_o),
  .arr_busy_i(arr_busy_i),
  .wr_en_o   (wr_en_o),
  .full_o    (full_o),
  .empty_o   (empty_o)
);

// File: tb/store_fwd_buffer_bench.sv
`timescale 1ns/1ps
module store_fwd_buffer_bench;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int WW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic st_valid_i = 0, st_hit_i = 0, ld_valid_i = 0, ld_hit_i = 0;
  logic drain_i = 0, arr_busy_i = 0;
  logic [AW-1:0] st_addr_i = '0, ld_addr_i = '0;
  logic [DW-1:0] st_data_i = '0;
  logic [WW-1:0] st_way_i = '0;
  logic st_ready_o, ld_fwd_o, ld_stall_o, drained_o, wr_en_o, full_o, empty_o;
  logic [DW-1:0] ld_fwd_data_o, wr_data_o;
  logic [AW-1:0] wr_addr_o;
  logic [WW-1:0] wr_way_o;

  store_fwd_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .WAY_W(WW)) u_store_fwd_buffer (
    .clk_i(clk), .rst_ni(rst_ni),
    .st_valid_i(st_valid_i), .st_hit_i(st_hit_i), .st_addr_i(st_addr_i),
    .st_data_i(st_data_i), .st_way_i(st_way_i), .st_ready_o(st_ready_o),
    .ld_valid_i(ld_valid_i), .ld_hit_i(ld_hit_i), .ld_addr_i(ld_addr_i),
    .ld_fwd_o(ld_fwd_o), .ld_fwd_data_o(ld_fwd_data_o), .ld_stall_o(ld_stall_o),
    .drain_i(drain_i), .drained_o(drained_o), .arr_busy_i(arr_busy_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_way_o(wr_way_o), .full_o(full_o), .empty_o(empty_o)
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] arr  [256];
  logic [DW-1:0] arch [256];
  logic [AW-1:0] wlog_addr [64];
  logic [DW-1:0] wlog_data [64];
  logic [WW-1:0] wlog_way  [64];
  int wcount = 0;
  logic [DW-1:0] exp_q [$];
  logic last_fwd = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // data array model and write log
  always @(posedge clk) begin
    if (rst_ni && wr_en_o) begin
      arr[wr_addr_o] <= wr_data_o;
      if (wcount < 64) begin
        wlog_addr[wcount] <= wr_addr_o;
        wlog_data[wcount] <= wr_data_o;
        wlog_way[wcount]  <= wr_way_o;
      end
      wcount <= wcount + 1;
    end
  end

  // scoreboard monitor: each accepted load pops one expected value
  always @(negedge clk) begin
    if (rst_ni && ld_valid_i && !ld_stall_o) begin
      logic [DW-1:0] obs, exp;
      obs = ld_fwd_o ? ld_fwd_data_o : arr[ld_addr_i];
      last_fwd = ld_fwd_o;
      if (exp_q.size() == 0) begin
        check("R5 load result (queue empty)", 32'(obs), 32'hFFFF_FFFF);
      end else begin
        exp = exp_q.pop_front();
        check("R5/R10 load value", 32'(obs), 32'(exp));
      end
    end
  end

  task automatic st(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic [WW-1:0] w, input logic h);
    st_valid_i = 1; st_hit_i = h; st_addr_i = a; st_data_i = d; st_way_i = w;
    @(negedge clk);
    while (h && !st_ready_o) begin
      @(posedge clk); #1 arr_busy_i = 0;
      @(negedge clk);
    end
    if (h) arch[a] = d;
    @(posedge clk); #1;
    st_valid_i = 0;
  endtask

  task automatic ld(input logic [AW-1:0] a, input logic h, output int stalls);
    ld_valid_i = 1; ld_hit_i = h; ld_addr_i = a;
    exp_q.push_back(arch[a]);
    stalls = 0;
    @(negedge clk);
    while (ld_stall_o) begin
      stalls++;
      @(posedge clk); #1 arr_busy_i = 0;
      @(negedge clk);
    end
    @(posedge clk); #1;
    ld_valid_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s, w0, cyc, nw;
    for (int i = 0; i < 256; i++) begin arr[i] = '0; arch[i] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check("R1 empty after reset", 32'(empty_o), 1);
    check("R1 not full after reset", 32'(full_o), 0);
    check("R1 no write after reset", 32'(wr_en_o), 0);
    check("R1 ready after reset", 32'(st_ready_o), 1);
    @(posedge clk); #1;

    // R2: park one hitting store, no write on its own
    st(8'h10, 16'h1111, 2'd1, 1'b1);
    @(negedge clk);
    check("R2 entry parked", 32'(empty_o), 0);
    check("R2 no write without trigger", 32'(wcount), 0);
    @(posedge clk); #1;
    // R3: missing store triggers retirement but is not parked
    st(8'h20, 16'h2222, 2'd0, 1'b0);
    @(negedge clk);
    check("R3 write count", 32'(wcount), 1);
    check("R3 written addr", 32'(wlog_addr[0]), 32'h10);
    check("R3 written data", 32'(wlog_data[0]), 32'h1111);
    check("R3 written way", 32'(wlog_way[0]), 1);
    check("R2 missed store not parked", 32'(empty_o), 1);
    @(posedge clk); #1;

    // R8/R9: fill with port busy
    arr_busy_i = 1;
    for (int k = 0; k < 4; k++) st(AW'(8'h30 + k), DW'(16'h3000 + k), WW'(k), 1'b1);
    @(negedge clk);
    check("R11 full after DEPTH stores", 32'(full_o), 1);
    check("R9 no write while busy", 32'(wcount), 1);
    @(posedge clk); #1;
    st_valid_i = 1; st_hit_i = 1; st_addr_i = 8'h34; st_data_i = 16'h3004; st_way_i = 2'd0;
    @(negedge clk);
    check("R8 stall when full and busy", 32'(st_ready_o), 0);
    @(posedge clk); #1 arr_busy_i = 0;
    @(negedge clk);
    check("R8 ready once an entry leaves", 32'(st_ready_o), 1);
    check("R3 oldest written", 32'(wr_addr_o), 32'h30);
    arch[8'h34] = 16'h3004;
    @(posedge clk); #1 st_valid_i = 0;

    // R5: two entries for 0x32, youngest must be forwarded
    st(8'h32, 16'hBEEF, 2'd3, 1'b1);
    ld(8'h32, 1'b1, s);
    check("R5 forwarded", 32'(last_fwd), 1);
    ld(8'h77, 1'b1, s);
    check("R10 no forward without match", 32'(last_fwd), 0);

    // R6: load miss drains four entries first
    w0 = wcount;
    ld(8'h40, 1'b0, s);
    check("R6 miss stall cycles", 32'(s), 4);
    check("R6 writes during stall", 32'(wcount - w0), 4);
    check("R4 order 1", 32'(wlog_addr[w0]), 32'h32);
    check("R4 order 2", 32'(wlog_data[w0+1]), 32'h3003);
    check("R4 order 4", 32'(wlog_data[w0+3]), 32'hBEEF);
    check("R4 order 4 way", 32'(wlog_way[w0+3]), 3);
    ld(8'h32, 1'b1, s);
    check("R10 served from array", 32'(last_fwd), 0);

    // R7: drain three entries
    arr_busy_i = 1;
    for (int k = 0; k < 3; k++) st(AW'(8'h60 + k), DW'(16'h6000 + k), 2'd2, 1'b1);
    arr_busy_i = 0;
    @(negedge clk);
    check("R7 drained low without request", 32'(drained_o), 0);
    @(posedge clk); #1 drain_i = 1;
    cyc = 0; nw = 0;
    @(negedge clk);
    while (!drained_o && cyc < 10) begin
      if (wr_en_o) nw++;
      cyc++;
      @(posedge clk); #1;
      @(negedge clk);
    end
    check("R7 drain cycles", 32'(cyc), 3);
    check("R7 drain writes", 32'(nw), 3);
    check("R11 empty after drain", 32'(empty_o), 1);
    @(posedge clk); #1 drain_i = 0;

    // random stream over eight words
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom % 16);
      arr_busy_i = ($urandom % 4 == 0);
      if (r < 7) st(AW'(8'h50 + $urandom % 8), DW'($urandom), WW'($urandom), ($urandom % 8) != 0);
      else ld(AW'(8'h50 + $urandom % 8), ($urandom % 5) != 0, s);
    end
    arr_busy_i = 0;
    drain_i = 1;
    @(negedge clk);
    while (!drained_o) begin @(posedge clk); #1; @(negedge clk); end
    @(posedge clk); #1 drain_i = 0;
    @(negedge clk);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (arr[i] !== arch[i]) bad++;
      check("R4 final array contents", 32'(bad), 0);
    end
    check("R5 scoreboard drained", 32'(exp_q.size()), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule